// File: doc/BRIEF.md
# Immediate Shift and Word-Add Execute Slice

This block is a purely combinational decode-and-execute slice for a 64-bit integer pipeline. It receives one 32-bit instruction word and the 64-bit value read for the first source register. It recognises the register-immediate shift forms in both full-width and 32-bit word variants, plus the word add-immediate. For each one it returns the 64-bit value that would be written back.

A single decoder classifies the instruction into one of three outcomes:

- **Handled:** `valid_o` is high and the result is driven.
- **Reserved shift encoding:** `illegal_o` is high and the result is zero.
- **Not this unit's business:** both flags are low and the result is zero, so a neighbouring unit can pick the instruction up.

Word forms run on the low 32 bits of the operand and always return a sign-extended 32-bit value. One shifter serves both widths.

Top module: `imm_shift_exec`

## Requirements
- R1: Opcode 7'b0010011 with funct3 (bits [14:12]) = 3'b001 and bits [31:26] = 6'b000000 is a full-width left shift. It gives valid_o=1 and result = rs1 shifted left by bits [25:20].
- R2: Opcode 7'b0010011 with funct3 = 3'b101 and bits [31:26] = 6'b000000 is a full-width logical right shift by bits [25:20]. It fills the vacated bits with zeros.
- R3: Opcode 7'b0010011 with funct3 = 3'b101 and bits [31:26] = 6'b010000 is a full-width arithmetic right shift by bits [25:20]. It fills the vacated bits with copies of rs1 bit 63.
- R4: Opcode 7'b0011011 with funct3 = 3'b001 or 3'b101, bit 25 = 0 and bits [31:26] = 6'b000000 is a word left or logical right shift. The shift acts on rs1[31:0] by bits [24:20], with zeros shifted in, and the 32-bit result is sign-extended to 64 bits. A shift amount of zero therefore returns the sign-extended low word.
- R5: Opcode 7'b0011011 with funct3 = 3'b101, bit 25 = 0 and bits [31:26] = 6'b010000 is a word arithmetic right shift. It fills from rs1 bit 31, and the result is sign-extended from bit 31.
- R6: Opcode 7'b0011011 with funct3 = 3'b000 is the word add. The result is rs1[31:0] plus the sign-extended bits [31:20], truncated to 32 bits and then sign-extended to 64 bits.
- R7: The following are reserved: a shift under either opcode whose bits [31:26] match neither pattern above, a left shift with bits [31:26] ≠ 0, and a word shift with bit 25 set. A reserved encoding gives illegal_o=1, valid_o=0 and result 0.
- R8: The following give valid_o=0, illegal_o=0 and result 0: any other opcode, opcode 7'b0010011 with funct3 other than 001/101, and opcode 7'b0011011 with funct3 other than 000/001/101.
- R9: valid_o and illegal_o are never high together.
- R10: Instruction bits [19:7] (destination and source register indices) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| src_i | input | 64 | First source operand value |
| result_o | output | 64 | Write-back value, zero unless valid_o |
| valid_o | output | 1 | Instruction recognised and executed here |
| illegal_o | output | 1 | Reserved shift encoding |

## Verification
Legality checking and shift execution happen in the same evaluation. A word shift with bit 25 set, or a shift with a stray upper immediate bit, still drives a real shift amount into the datapath while the decoder must veto it. The bench provokes this by taking legal encodings over random operands and flipping bit 25 or random bits of [31:26]. It then judges that the legality flag rises, valid falls and the shifted value never reaches the result.

// File: rtl/imm_shift_pkg.sv
package imm_shift_pkg;

  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_IMM32 = 7'b0011011;

  localparam logic [2:0] F3_ADD = 3'b000;
  localparam logic [2:0] F3_SL  = 3'b001;
  localparam logic [2:0] F3_SR  = 3'b101;

  localparam logic [5:0] UP_LOGIC = 6'b000000;
  localparam logic [5:0] UP_ARITH = 6'b010000;

  typedef enum logic [2:0] {
    K_NONE,
    K_SLL,
    K_SRL,
    K_SRA,
    K_ADDW
  } kind_e;

endpackage

// File: rtl/imm_shift_decode.sv
module imm_shift_decode
  import imm_shift_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32
) (
  input  logic [31:0]               instr_i,
  output kind_e                     kind_o,
  output logic                      word_o,
  output logic                      bad_o,
  output logic [$clog2(XLEN)-1:0]   amt_o,
  output logic [11:0]               imm_o
);

  localparam int unsigned SHW  = $clog2(XLEN);
  localparam int unsigned WSHW = $clog2(WLEN);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [5:0] up;
  logic       wide_bit;

  assign opc      = instr_i[6:0];
  assign f3       = instr_i[14:12];
  assign up       = instr_i[31:26];
  assign wide_bit = instr_i[20 + WSHW];
  assign imm_o    = instr_i[31:20];

  always_comb begin
    kind_o = K_NONE;
    word_o = 1'b0;
    bad_o  = 1'b0;
    amt_o  = instr_i[20 +: SHW];
    case (opc)
      OPC_IMM: begin
        if (f3 == F3_SL) begin
          if (up == UP_LOGIC) kind_o = K_SLL;
          else                bad_o  = 1'b1;
        end else if (f3 == F3_SR) begin
          if (up == UP_LOGIC)      kind_o = K_SRL;
          else if (up == UP_ARITH) kind_o = K_SRA;
          else                     bad_o  = 1'b1;
        end
      end
      OPC_IMM32: begin
        amt_o[SHW-1:WSHW] = '0;
        if (f3 == F3_ADD) begin
          kind_o = K_ADDW;
          word_o = 1'b1;
        end else if (f3 == F3_SL) begin
          if (up == UP_LOGIC && !wide_bit) begin
            kind_o = K_SLL;
            word_o = 1'b1;
          end else begin
            bad_o = 1'b1;
          end
        end else if (f3 == F3_SR) begin
          if (wide_bit) begin
            bad_o = 1'b1;
          end else if (up == UP_LOGIC) begin
            kind_o = K_SRL;
            word_o = 1'b1;
          end else if (up == UP_ARITH) begin
            kind_o = K_SRA;
            word_o = 1'b1;
          end else begin
            bad_o = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/imm_shift_core.sv
module imm_shift_core
  import imm_shift_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32
) (
  input  logic [XLEN-1:0]         src_i,
  input  logic [$clog2(XLEN)-1:0] amt_i,
  input  kind_e                   kind_i,
  input  logic                    word_i,
  output logic [XLEN-1:0]         res_o
);

  localparam int unsigned EXT = XLEN - WLEN;

  logic [XLEN-1:0] opnd;
  logic [XLEN-1:0] raw;

  always_comb begin
    if (!word_i)               opnd = src_i;
    else if (kind_i == K_SRA)  opnd = {{EXT{src_i[WLEN-1]}}, src_i[WLEN-1:0]};
    else                       opnd = {{EXT{1'b0}}, src_i[WLEN-1:0]};
  end

  always_comb begin
    case (kind_i)
      K_SLL:   raw = opnd << amt_i;
      K_SRL:   raw = opnd >> amt_i;
      K_SRA:   raw = $unsigned($signed(opnd) >>> amt_i);
      default: raw = '0;
    endcase
  end

  assign res_o = word_i ? {{EXT{raw[WLEN-1]}}, raw[WLEN-1:0]} : raw;

  always_comb begin
    if (word_i && kind_i != K_NONE && kind_i != K_ADDW) begin
      AST_WORD_AMT_RANGE: assert (amt_i < XLEN'(WLEN)) else $error("word shift amount out of range"); // R4
    end
  end

endmodule

// File: rtl/imm_shift_addw.sv
module imm_shift_addw #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32
) (
  input  logic [XLEN-1:0] src_i,
  input  logic [11:0]     imm_i,
  output logic [XLEN-1:0] res_o
);

  localparam int unsigned EXT = XLEN - WLEN;

  logic [WLEN-1:0] imm_w;
  logic [WLEN-1:0] sum;

  assign imm_w = {{(WLEN-12){imm_i[11]}}, imm_i};
  assign sum   = src_i[WLEN-1:0] + imm_w;
  assign res_o = {{EXT{sum[WLEN-1]}}, sum};

endmodule

// File: rtl/imm_shift_exec.sv
module imm_shift_exec
  import imm_shift_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] result_o,
  output logic            valid_o,
  output logic            illegal_o
);

  localparam int unsigned SHW = $clog2(XLEN);

  kind_e           kind;
  logic            word;
  logic            bad;
  logic [SHW-1:0]  amt;
  logic [11:0]     imm;
  logic [XLEN-1:0] sh_res;
  logic [XLEN-1:0] add_res;

  imm_shift_decode #(.XLEN(XLEN), .WLEN(WLEN)) u_dec (
    .instr_i (instr_i),
    .kind_o  (kind),
    .word_o  (word),
    .bad_o   (bad),
    .amt_o   (amt),
    .imm_o   (imm)
  );

  imm_shift_core #(.XLEN(XLEN), .WLEN(WLEN)) u_core (
    .src_i  (src_i),
    .amt_i  (amt),
    .kind_i (kind),
    .word_i (word),
    .res_o  (sh_res)
  );

  imm_shift_addw #(.XLEN(XLEN), .WLEN(WLEN)) u_addw (
    .src_i (src_i),
    .imm_i (imm),
    .res_o (add_res)
  );

  always_comb begin
    valid_o   = (kind != K_NONE) && !bad;
    illegal_o = bad;
    if (!valid_o)            result_o = '0;
    else if (kind == K_ADDW) result_o = add_res;
    else                     result_o = sh_res;
  end

  always_comb begin
    AST_FLAGS_EXCLUSIVE: assert (!(valid_o && illegal_o)) else $error("valid and illegal together"); // R9
    if (illegal_o) begin
      AST_ILLEGAL_ZERO: assert (result_o == '0) else $error("illegal encoding leaked a result"); // R7
    end
    if (!valid_o) begin
      AST_IDLE_ZERO: assert (result_o == '0) else $error("unhandled encoding drove a result"); // R8
    end
    if (valid_o && word) begin
      AST_WORD_SEXT: assert (result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}}) else $error("word result not sign-extended"); // R4
    end
  end

endmodule

// File: tb/imm_shift_exec_bench.sv
module imm_shift_exec_bench;

  logic        clk;
  logic [31:0] instr;
  logic [63:0] src;
  logic [63:0] result;
  logic        valid;
  logic        illegal;

  int unsigned n_tests;
  int unsigned n_fail;
  bit          done;

  imm_shift_exec u_imm_shift_exec (
    .instr_i   (instr),
    .src_i     (src),
    .result_o  (result),
    .valid_o   (valid),
    .illegal_o (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic [31:0] enc(input [6:0] opc, input [2:0] f3, input [11:0] imm,
                                input [4:0] rd, input [4:0] rs);
    return {imm, rs, f3, rd, opc};
  endfunction

  function automatic [63:0] sx32(input [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic void model(input [31:0] ins, input [63:0] a,
                                output logic [63:0] r, output logic v, output logic il);
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [5:0]  up;
    logic [31:0] lo;
    opc = ins[6:0]; f3 = ins[14:12]; up = ins[31:26]; lo = a[31:0];
    r = 64'd0; v = 1'b0; il = 1'b0;
    if (opc == 7'b0010011) begin
      if (f3 == 3'b001) begin
        if (up == 6'd0) begin v = 1'b1; r = a << ins[25:20]; end
        else il = 1'b1;
      end else if (f3 == 3'b101) begin
        if (up == 6'd0) begin v = 1'b1; r = a >> ins[25:20]; end
        else if (up == 6'b010000) begin
          v = 1'b1;
          r = a >> ins[25:20];
          for (int i = 0; i < 64; i++) if (i >= 64 - int'(ins[25:20])) r[i] = a[63];
        end else il = 1'b1;
      end
    end else if (opc == 7'b0011011) begin
      if (f3 == 3'b000) begin
        v = 1'b1;
        r = sx32(lo + {{20{ins[31]}}, ins[31:20]});
      end else if (f3 == 3'b001) begin
        if (up == 6'd0 && !ins[25]) begin v = 1'b1; r = sx32(lo << ins[24:20]); end
        else il = 1'b1;
      end else if (f3 == 3'b101) begin
        if (ins[25]) il = 1'b1;
        else if (up == 6'd0) begin v = 1'b1; r = sx32(lo >> ins[24:20]); end
        else if (up == 6'b010000) begin
          logic [31:0] t;
          v = 1'b1;
          t = lo >> ins[24:20];
          for (int i = 0; i < 32; i++) if (i >= 32 - int'(ins[24:20])) t[i] = lo[31];
          r = sx32(t);
        end else il = 1'b1;
      end
    end
  endfunction

  task automatic apply(input [31:0] ins, input [63:0] a, input string tag);
    logic [63:0] er;
    logic        ev;
    logic        eil;
    @(negedge clk);
    instr = ins;
    src   = a;
    #1;
    model(ins, a, er, ev, eil);
    n_tests++;
    if (result !== er || valid !== ev || illegal !== eil) begin
      n_fail++;
      $display("FAIL %s instr=%h src=%h: got res=%h v=%b il=%b, expected res=%h v=%b il=%b",
               tag, ins, a, result, valid, illegal, er, ev, eil);
    end
    if (valid && illegal) begin
      n_fail++;
      $display("FAIL R9 instr=%h: got v=%b il=%b, expected not both high", ins, valid, illegal);
    end
  endtask

  task automatic expect_val(input [31:0] ins, input [63:0] a, input [63:0] er, input string tag);
    @(negedge clk);
    instr = ins;
    src   = a;
    #1;
    n_tests++;
    if (result !== er || valid !== 1'b1 || illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL %s instr=%h: got res=%h v=%b il=%b, expected res=%h v=1 il=0",
               tag, ins, result, valid, illegal, er);
    end
  endtask

  function automatic [4:0] rnd5();
    return 5'($urandom);
  endfunction

  function automatic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    void'($urandom(32'h5EED_0042));
    instr = 32'd0;
    src   = 64'd0;

    @(negedge clk);
    #1;
    n_tests++;
    if (result !== 64'd0 || valid !== 1'b0 || illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 idle word: got res=%h v=%b il=%b, expected res=0 v=0 il=0", result, valid, illegal);
    end

    // Directed corner cases
    expect_val(enc(7'b0010011, 3'b001, 12'd63, 5'd1, 5'd2), 64'd1, 64'h8000_0000_0000_0000, "R1");
    expect_val(enc(7'b0010011, 3'b101, 12'd63, 5'd1, 5'd2), 64'h8000_0000_0000_0000, 64'd1, "R2");
    expect_val(enc(7'b0010011, 3'b101, 12'h400 | 12'd63, 5'd1, 5'd2),
               64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    expect_val(enc(7'b0011011, 3'b101, 12'd0, 5'd3, 5'd4),
               64'h0000_0000_8000_0000, 64'hFFFF_FFFF_8000_0000, "R4");
    expect_val(enc(7'b0011011, 3'b101, 12'd1, 5'd3, 5'd4),
               64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7FFF_FFFF, "R4");
    expect_val(enc(7'b0011011, 3'b001, 12'd31, 5'd3, 5'd4), 64'd1, 64'hFFFF_FFFF_8000_0000, "R4");
    expect_val(enc(7'b0011011, 3'b101, 12'h400 | 12'd31, 5'd3, 5'd4),
               64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    expect_val(enc(7'b0011011, 3'b000, 12'd0, 5'd5, 5'd6),
               64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_9ABC_DEF0, "R6");
    expect_val(enc(7'b0011011, 3'b000, 12'd1, 5'd5, 5'd6),
               64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_8000_0000, "R6");
    expect_val(enc(7'b0011011, 3'b000, 12'hFFF, 5'd5, 5'd6), 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R6");

    // Reserved encodings (R7) and foreign encodings (R8)
    apply(enc(7'b0011011, 3'b001, 12'h020, 5'd1, 5'd1), 64'hFFFF, "R7");
    apply(enc(7'b0011011, 3'b101, 12'h425, 5'd1, 5'd1), 64'hFFFF, "R7");
    apply(enc(7'b0010011, 3'b101, 12'h443, 5'd1, 5'd1), 64'hFFFF, "R7");
    apply(enc(7'b0010011, 3'b001, 12'h400, 5'd1, 5'd1), 64'hFFFF, "R7");
    apply(enc(7'b0010011, 3'b000, 12'h005, 5'd1, 5'd1), 64'hFFFF, "R8");
    apply(enc(7'b0110011, 3'b001, 12'h003, 5'd1, 5'd1), 64'hFFFF, "R8");
    apply(enc(7'b0011011, 3'b010, 12'h003, 5'd1, 5'd1), 64'hFFFF, "R8");

    // R10: register index fields do not matter
    expect_val(enc(7'b0010011, 3'b001, 12'd4, 5'd0, 5'd0), 64'h1, 64'h10, "R10");
    expect_val(enc(7'b0010011, 3'b001, 12'd4, 5'd31, 5'd31), 64'h1, 64'h10, "R10");

    // Every shift amount, full width
    for (int sh = 0; sh < 64; sh++) begin
      apply(enc(7'b0010011, 3'b001, 12'(sh), rnd5(), rnd5()), rnd64(), "R1");
      apply(enc(7'b0010011, 3'b101, 12'(sh), rnd5(), rnd5()), rnd64(), "R2");
      apply(enc(7'b0010011, 3'b101, 12'h400 | 12'(sh), rnd5(), rnd5()), rnd64(), "R3");
      apply(enc(7'b0010011, 3'b101, 12'h400 | 12'(sh), rnd5(), rnd5()),
            rnd64() | 64'h8000_0000_0000_0000, "R3");
    end

    // Every shift amount, word forms, then each with bit 25 flipped
    for (int sh = 0; sh < 32; sh++) begin
      apply(enc(7'b0011011, 3'b001, 12'(sh), rnd5(), rnd5()), rnd64(), "R4");
      apply(enc(7'b0011011, 3'b101, 12'(sh), rnd5(), rnd5()), rnd64(), "R4");
      apply(enc(7'b0011011, 3'b101, 12'h400 | 12'(sh), rnd5(), rnd5()), rnd64(), "R5");
      apply(enc(7'b0011011, 3'b101, 12'h400 | 12'(sh), rnd5(), rnd5()),
            rnd64() | 64'h8000_0000, "R5");
      apply(enc(7'b0011011, 3'b001, 12'h020 | 12'(sh), rnd5(), rnd5()), rnd64(), "R7");
      apply(enc(7'b0011011, 3'b101, 12'h020 | 12'(sh), rnd5(), rnd5()), rnd64(), "R7");
      apply(enc(7'b0011011, 3'b101, 12'h420 | 12'(sh), rnd5(), rnd5()), rnd64(), "R7");
    end

    // Word add with random immediates
    for (int i = 0; i < 300; i++)
      apply(enc(7'b0011011, 3'b000, 12'($urandom), rnd5(), rnd5()), rnd64(), "R6");

    // Random upper immediate bits on shifts: mostly reserved
    for (int i = 0; i < 400; i++) begin
      logic [2:0] f3;
      logic [6:0] opc;
      f3  = ($urandom % 2 == 0) ? 3'b001 : 3'b101;
      opc = ($urandom % 2 == 0) ? 7'b0010011 : 7'b0011011;
      apply(enc(opc, f3, 12'($urandom), rnd5(), rnd5()), rnd64(), "R7");
    end

    // Fully random instruction words over the two opcodes and others
    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      w = $urandom;
      case ($urandom % 3)
        0: w[6:0] = 7'b0010011;
        1: w[6:0] = 7'b0011011;
        default: ;
      endcase
      apply(w, rnd64(), "R8");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no completion, expected end of stimulus");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule